// File: doc/BRIEF.md
# MSI Vector Table Delivery Engine

This block turns message-signalled interrupt writes into interrupt deliveries toward a presenter. The per-source state is kept in a table in system memory, not in the block. For each incoming event the block takes a source number from the write's address and data. It checks that number against the configuration, locates the source's 64-bit entry in the table and fetches it over a byte-addressed request/acknowledge memory port. From the entry's pending (P) and queued (Q) bits it decides what to do. It then writes a single status byte back into the entry and, when the source fires, raises a one-cycle delivery carrying the target server, the priority and the global interrupt number.

The same event port also carries two variants. A forced resend ignores the stored P/Q bits; a presenter uses it to replay interrupts it earlier rejected. A fast-injection write takes no data bits and skips the partition check, and the block pulses an unlock strobe when it is done with it. Only one event is in flight at a time. `ev_ready` is low from the entry fetch until the last write-back is acknowledged.

Top module: `msi_vte_engine`

## Requirements
- R1: When `cfg_tbl_en` is 0, an accepted event makes no memory request and produces no delivery.
- R2: A source number greater than or equal to `cfg_tbl_len` is dropped with no memory request.
- R3: The entry address is (`cfg_tbl_base` with bits [11:0] cleared) + source × 128 when `cfg_large` is 1, and + source × 16 when it is 0.
- R4: The source number is `ev_addr[19:4]` OR `ev_data[4:0]`. A source at or above the effective count is dropped with no memory request, where the effective count is `cfg_src_count` limited to 2048.
- R5: When `ev_pe_valid` is 1 on a normal event, an entry whose partition field (bits [63:48]) differs from `ev_pe` ends the event after the fetch, with no write and no delivery.
- R6: The entry is the 8 bytes at the entry address read as a big-endian word. P is bit 24, generation is bits [26:25], Q is bit 16, priority is bits [7:0] and server is bits [47:32]. With P=0, Q=0 and priority not 0xFF, the block writes byte 0x01 | (gen << 1) at entry+4. It then delivers server >> 2, the priority, and source + `cfg_irq_base`.
- R7: With P=0, Q=0 and priority 0xFF, the block writes 0x01 at entry+5 and delivers nothing.
- R8: With P=1 and Q=0, the block writes 0x01 at entry+5 and delivers nothing.
- R9: With Q=1 (and no force), the entry is fetched and nothing is written or delivered.
- R10: When `ev_force` is 1, the stored P/Q bits are treated as 0, 0.
- R11: When `ev_ffi` is 1, the data bits are taken as 0 and the partition check is skipped. `ffi_unlock` pulses exactly once, when the event ends, whether it was dropped or not.
- R12: After reset `ev_ready` is 1 and `mem_req` is 0. `ev_ready` is 0 from the cycle after an accepted valid event until its final memory acknowledge. A request holds its address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Engine idle, event accepted when valid |
| ev_addr | input | 64 | Message write address |
| ev_data | input | 16 | Message write data |
| ev_pe_valid | input | 1 | Requester partition supplied |
| ev_pe | input | 16 | Requester partition number |
| ev_force | input | 1 | Forced resend, stored P/Q ignored |
| ev_ffi | input | 1 | Fast-injection event |
| cfg_tbl_base | input | 64 | Table base address |
| cfg_tbl_len | input | 17 | Table length in entries |
| cfg_tbl_en | input | 1 | Table enable |
| cfg_large | input | 1 | 128-byte entry stride |
| cfg_irq_base | input | 32 | Global interrupt number offset |
| cfg_src_count | input | 16 | Source count before clamping |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a byte write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 64 | Read word, lowest-address byte in [63:56] |
| irq_valid | output | 1 | Delivery strobe |
| irq_server | output | 16 | Target server |
| irq_prio | output | 8 | Delivery priority |
| irq_num | output | 32 | Global interrupt number |
| ffi_unlock | output | 1 | Fast-injection lock release strobe |

## Verification
The bench targets the boundaries where sources are rejected. It probes the last legal table entry and the first illegal one, and a source count above 2048 where source 2048 must fail while 2047 passes. A design that compared with the wrong inequality, or skipped the clamp, would fetch an entry it must not touch, and the access counter would show it. The bench walks one source through the whole P/Q sequence and then forces it. A design that wrote the wrong byte offset, or lost the generation bits, would leave the wrong bytes in memory. A design that ignored the force would stay silent when it should deliver. Partition mismatches are tried both with and without fast injection, so a partition check applied to the wrong kind of event shows up either as a missing delivery or as a delivery that should have been dropped.

// File: rtl/msi_vte_pkg.sv
package msi_vte_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } vte_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SET_P = 2'd1,
        ACT_SET_Q = 2'd2
    } vte_act_e;
endpackage

// File: rtl/msi_vte_locate.sv
module msi_vte_locate #(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 16,
    parameter int SRC_W    = 16,
    parameter int LEN_W    = 17,
    parameter int CNT_W    = 16,
    parameter int MAX_SRC  = 2048,
    parameter int BASE_LSB = 12,
    parameter int SMALL_SH = 4,
    parameter int LARGE_SH = 7,
    parameter int DLO_W    = 5
) (
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_ffi,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic [LEN_W-1:0]  cfg_tbl_len,
    input  logic              cfg_tbl_en,
    input  logic              cfg_large,
    input  logic [CNT_W-1:0]  cfg_src_count,
    output logic [SRC_W-1:0]  src,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              src_ok
);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));
    localparam logic [31:0]       MAX_CNT   = 32'(MAX_SRC);

    logic [DLO_W-1:0] data_lo;
    logic [31:0]      cnt_eff;
    logic [ADDR_W-1:0] base_m;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        data_lo    = ev_ffi ? '0 : ev_data[DLO_W-1:0];
        src        = ev_addr[SMALL_SH +: SRC_W] | SRC_W'(data_lo);
        cnt_eff    = (32'(cfg_src_count) > MAX_CNT) ? MAX_CNT : 32'(cfg_src_count);
        src_ok     = cfg_tbl_en && (32'(src) < 32'(cfg_tbl_len)) && (32'(src) < cnt_eff);
        base_m     = cfg_tbl_base & BASE_MASK;
        offs       = cfg_large ? (ADDR_W'(src) << LARGE_SH) : (ADDR_W'(src) << SMALL_SH);
        entry_addr = base_m + offs;
    end
endmodule

// File: rtl/msi_vte_gate.sv
module msi_vte_gate
    import msi_vte_pkg::*;
#(
    parameter int SRV_LSB = 32,
    parameter int SRV_W   = 16,
    parameter int PRI_LSB = 0,
    parameter int PE_LSB  = 48,
    parameter int PE_W    = 16,
    parameter int P_BIT   = 24,
    parameter int GEN_LSB = 25,
    parameter int GEN_W   = 2,
    parameter int Q_BIT   = 16
) (
    input  logic [63:0]      ive,
    input  logic             force_pq,
    input  logic             pe_chk,
    input  logic [PE_W-1:0]  pe_req,
    output logic             pe_ok,
    output vte_act_e         act,
    output logic [7:0]       wbyte,
    output logic [SRV_W-1:0] server,
    output logic [7:0]       prio
);
    localparam logic [7:0] MASKED_PRIO = 8'hFF;

    logic [1:0]       pq;
    logic [GEN_W-1:0] gen;

    always_comb begin
        gen    = ive[GEN_LSB +: GEN_W];
        prio   = ive[PRI_LSB +: 8];
        server = ive[SRV_LSB +: SRV_W] >> 2;
        pe_ok  = !pe_chk || (ive[PE_LSB +: PE_W] == pe_req);
        pq     = force_pq ? 2'b00 : {ive[P_BIT], ive[Q_BIT]};
        act    = ACT_NONE;
        wbyte  = 8'h01;
        unique case (pq)
            2'b00: begin
                if (prio == MASKED_PRIO) begin
                    act = ACT_SET_Q;
                end else begin
                    act   = ACT_SET_P;
                    wbyte = 8'h01 | (8'(gen) << 1);
                end
            end
            2'b10:   act = ACT_SET_Q;
            default: act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/msi_vte_engine.sv
module msi_vte_engine
    import msi_vte_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 16,
    parameter int SRC_W    = 16,
    parameter int LEN_W    = 17,
    parameter int CNT_W    = 16,
    parameter int IRQ_W    = 32,
    parameter int MAX_SRC  = 2048,
    parameter int BASE_LSB = 12,
    parameter int SRV_LSB  = 32,
    parameter int SRV_W    = 16,
    parameter int PRI_LSB  = 0,
    parameter int PE_LSB   = 48,
    parameter int PE_W     = 16,
    parameter int P_BIT    = 24,
    parameter int GEN_LSB  = 25,
    parameter int GEN_W    = 2,
    parameter int Q_BIT    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_pe_valid,
    input  logic [PE_W-1:0]   ev_pe,
    input  logic              ev_force,
    input  logic              ev_ffi,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic [LEN_W-1:0]  cfg_tbl_len,
    input  logic              cfg_tbl_en,
    input  logic              cfg_large,
    input  logic [IRQ_W-1:0]  cfg_irq_base,
    input  logic [CNT_W-1:0]  cfg_src_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              irq_valid,
    output logic [SRV_W-1:0]  irq_server,
    output logic [7:0]        irq_prio,
    output logic [IRQ_W-1:0]  irq_num,
    output logic              ffi_unlock
);
    // byte offsets inside a big-endian entry for the P and Q status bytes
    localparam logic [ADDR_W-1:0] P_OFF = ADDR_W'(7 - P_BIT / 8);
    localparam logic [ADDR_W-1:0] Q_OFF = ADDR_W'(7 - Q_BIT / 8);

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [ADDR_W-1:0] entry;
        logic              force_pq;
        logic              pe_chk;
        logic [PE_W-1:0]   pe;
        logic              ffi;
    } ev_ctx_t;

    typedef struct packed {
        vte_state_e        st;
        ev_ctx_t           ev;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wbyte;
        logic              deliver;
        logic [SRV_W-1:0]  srv;
        logic [7:0]        prio;
        logic [IRQ_W-1:0]  num;
        logic              irq;
        logic              unlock;
    } vte_regs_t;

    vte_regs_t q, d;

    logic [SRC_W-1:0]  loc_src;
    logic [ADDR_W-1:0] loc_entry;
    logic              loc_ok;
    logic              g_pe_ok;
    vte_act_e          g_act;
    logic [7:0]        g_wbyte;
    logic [SRV_W-1:0]  g_srv;
    logic [7:0]        g_prio;

    msi_vte_locate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .LEN_W(LEN_W),
        .CNT_W(CNT_W), .MAX_SRC(MAX_SRC), .BASE_LSB(BASE_LSB)
    ) u_locate (
        .ev_addr      (ev_addr),
        .ev_data      (ev_data),
        .ev_ffi       (ev_ffi),
        .cfg_tbl_base (cfg_tbl_base),
        .cfg_tbl_len  (cfg_tbl_len),
        .cfg_tbl_en   (cfg_tbl_en),
        .cfg_large    (cfg_large),
        .cfg_src_count(cfg_src_count),
        .src          (loc_src),
        .entry_addr   (loc_entry),
        .src_ok       (loc_ok)
    );

    msi_vte_gate #(
        .SRV_LSB(SRV_LSB), .SRV_W(SRV_W), .PRI_LSB(PRI_LSB), .PE_LSB(PE_LSB),
        .PE_W(PE_W), .P_BIT(P_BIT), .GEN_LSB(GEN_LSB), .GEN_W(GEN_W), .Q_BIT(Q_BIT)
    ) u_gate (
        .ive     (mem_rdata),
        .force_pq(q.ev.force_pq),
        .pe_chk  (q.ev.pe_chk),
        .pe_req  (q.ev.pe),
        .pe_ok   (g_pe_ok),
        .act     (g_act),
        .wbyte   (g_wbyte),
        .server  (g_srv),
        .prio    (g_prio)
    );

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        d.unlock = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ev_valid) begin
                    d.ev.src      = loc_src;
                    d.ev.entry    = loc_entry;
                    d.ev.force_pq = ev_force;
                    d.ev.pe_chk   = ev_pe_valid && !ev_ffi;
                    d.ev.pe       = ev_pe;
                    d.ev.ffi      = ev_ffi;
                    if (loc_ok) begin
                        d.st = ST_FETCH;
                    end else begin
                        d.unlock = ev_ffi;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    if (!g_pe_ok || g_act == ACT_NONE) begin
                        d.st     = ST_IDLE;
                        d.unlock = q.ev.ffi;
                    end else begin
                        d.st      = ST_WRITE;
                        d.waddr   = q.ev.entry + ((g_act == ACT_SET_P) ? P_OFF : Q_OFF);
                        d.wbyte   = g_wbyte;
                        d.deliver = (g_act == ACT_SET_P);
                        d.srv     = g_srv;
                        d.prio    = g_prio;
                        d.num     = cfg_irq_base + IRQ_W'(q.ev.src);
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    d.st     = ST_IDLE;
                    d.irq    = q.deliver;
                    d.unlock = q.ev.ffi;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ev_ready   = (q.st == ST_IDLE);
    assign mem_req    = (q.st != ST_IDLE);
    assign mem_we     = (q.st == ST_WRITE);
    assign mem_addr   = (q.st == ST_WRITE) ? q.waddr : q.ev.entry;
    assign mem_wdata  = q.wbyte;
    assign irq_valid  = q.irq;
    assign irq_server = q.srv;
    assign irq_prio   = q.prio;
    assign irq_num    = q.num;
    assign ffi_unlock = q.unlock;
endmodule

// File: rtl/msi_vte_engine_chk.sv
module msi_vte_engine_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              cfg_tbl_en,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              irq_valid,
    input logic [7:0]        irq_prio
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R1
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_ready && !cfg_tbl_en |=> !mem_req);

    // R6
    irq_after_pwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(mem_req && mem_we && mem_ack && mem_wdata[0]));

    // R7
    masked_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_prio != 8'hFF);

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> !ev_ready);
endmodule

bind msi_vte_engine msi_vte_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .cfg_tbl_en(cfg_tbl_en),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq_valid (irq_valid),
    .irq_prio  (irq_prio)
);

// File: tb/msi_vte_engine_tb.sv
module msi_vte_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [63:0] ev_addr = '0;
    logic [15:0] ev_data = '0;
    logic        ev_pe_valid = 1'b0;
    logic [15:0] ev_pe = '0;
    logic        ev_force = 1'b0;
    logic        ev_ffi = 1'b0;
    logic [63:0] cfg_tbl_base = 64'h1000_0ABC;
    logic [16:0] cfg_tbl_len = 17'd300;
    logic        cfg_tbl_en = 1'b1;
    logic        cfg_large = 1'b0;
    logic [31:0] cfg_irq_base = 32'h400;
    logic [15:0] cfg_src_count = 16'd4000;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        irq_valid;
    logic [15:0] irq_server;
    logic [7:0]  irq_prio;
    logic [31:0] irq_num;
    logic        ffi_unlock;

    int n_chk = 0, n_err = 0;
    int n_acc = 0, n_irq = 0, n_unl = 0;
    logic [15:0] got_srv;
    logic [7:0]  got_prio;
    logic [31:0] got_num;
    logic [7:0]  mem [logic [63:0]];

    always #4 clk = ~clk;

    msi_vte_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_addr(ev_addr), .ev_data(ev_data), .ev_pe_valid(ev_pe_valid), .ev_pe(ev_pe),
        .ev_force(ev_force), .ev_ffi(ev_ffi), .cfg_tbl_base(cfg_tbl_base),
        .cfg_tbl_len(cfg_tbl_len), .cfg_tbl_en(cfg_tbl_en), .cfg_large(cfg_large),
        .cfg_irq_base(cfg_irq_base), .cfg_src_count(cfg_src_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_valid(irq_valid),
        .irq_server(irq_server), .irq_prio(irq_prio), .irq_num(irq_num),
        .ffi_unlock(ffi_unlock)
    );

    function automatic logic [7:0] rd8(logic [63:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [63:0] rd64(logic [63:0] a);
        logic [63:0] v = '0;
        for (int i = 0; i < 8; i++) v = {v[55:0], rd8(a + 64'(i))};
        return v;
    endfunction

    task automatic wr64(logic [63:0] a, logic [63:0] v);
        for (int i = 0; i < 8; i++) mem[a + 64'(i)] = v[63-8*i -: 8];
    endtask

    function automatic logic [63:0] mk_ive(logic [15:0] pe, logic [15:0] srv, logic p,
                                           logic q, logic [1:0] gen, logic [7:0] prio);
        return {pe, srv, 5'b0, gen, p, 7'b0, q, 8'h00, prio};
    endfunction

    function automatic logic [63:0] ent_addr(logic [15:0] src);
        return (cfg_tbl_base & ~64'hFFF) + (cfg_large ? 64'(src) * 128 : 64'(src) * 16);
    endfunction

    // memory responder and output monitor, both away from the active edge
    always @(negedge clk) begin
        if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
            mem_ack = 1'b1;
            n_acc++;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata = rd64(mem_addr);
        end else begin
            mem_ack = 1'b0;
        end
        if (irq_valid) begin
            n_irq++;
            got_srv  = irq_server;
            got_prio = irq_prio;
            got_num  = irq_num;
        end
        if (ffi_unlock) n_unl++;
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_ev(logic [63:0] addr, logic [15:0] data, logic pev, logic [15:0] pe,
                          logic frc, logic ffi, string tag_hint);
        logic [15:0] src, cnt;
        logic [63:0] ent, ive;
        logic ok, pe_fail, act_p, act_q;
        logic [1:0] pq;
        logic [7:0] b4, b5;
        int exp_acc;
        string tag;
        src = addr[19:4] | (ffi ? 16'h0 : {11'b0, data[4:0]});
        cnt = (cfg_src_count > 16'd2048) ? 16'd2048 : cfg_src_count;
        ok = cfg_tbl_en && (17'(src) < cfg_tbl_len) && (src < cnt);
        ent = ent_addr(src);
        ive = rd64(ent);
        pe_fail = pev && !ffi && (ive[63:48] != pe);
        pq = frc ? 2'b00 : {ive[24], ive[16]};
        act_p = ok && !pe_fail && pq == 2'b00 && ive[7:0] != 8'hFF;
        act_q = ok && !pe_fail && (pq == 2'b10 || (pq == 2'b00 && ive[7:0] == 8'hFF));
        b4 = act_p ? (8'h01 | {5'b0, ive[26:25], 1'b0}) : rd8(ent + 4);
        b5 = act_q ? 8'h01 : rd8(ent + 5);
        exp_acc = !ok ? 0 : (act_p || act_q) ? 2 : 1;
        if (!cfg_tbl_en)             tag = "R1";
        else if (17'(src) >= cfg_tbl_len) tag = "R2";
        else if (src >= cnt)         tag = "R4";
        else if (pe_fail)            tag = "R5";
        else if (frc)                tag = "R10";
        else if (act_p)              tag = "R6";
        else if (act_q && pq == 2'b00) tag = "R7";
        else if (act_q)              tag = "R8";
        else                         tag = "R9";
        if (tag_hint != "") tag = tag_hint;
        @(negedge clk);
        n_acc = 0; n_irq = 0; n_unl = 0;
        ev_addr = addr; ev_data = data; ev_pe_valid = pev; ev_pe = pe;
        ev_force = frc; ev_ffi = ffi; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R12", "ready after accept", 64'(ev_ready), 64'(!ok));
        while (!(ev_ready && !mem_req)) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(tag, "memory accesses", 64'(n_acc), 64'(exp_acc));
        chk(tag, "deliveries", 64'(n_irq), 64'(act_p));
        if (act_p) begin
            chk(tag, "server", 64'(got_srv), 64'(ive[47:32] >> 2));
            chk(tag, "prio", 64'(got_prio), 64'(ive[7:0]));
            chk(tag, "irq number", 64'(got_num), 64'(cfg_irq_base + 32'(src)));
        end
        chk(tag, "P byte", 64'(rd8(ent + 4)), 64'(b4));
        chk(tag, "Q byte", 64'(rd8(ent + 5)), 64'(b5));
        chk("R11", "unlock pulses", 64'(n_unl), 64'(ffi));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "reset ready", 64'(ev_ready), 64'd1);
        chk("R12", "reset mem_req", 64'(mem_req), 64'd0);
        chk("R6", "reset irq_valid", 64'(irq_valid), 64'd0);

        // P/Q walk on one source
        wr64(ent_addr(16'd5), mk_ive(16'h0007, 16'h0123, 1'b0, 1'b0, 2'd2, 8'h10));
        run_ev(64'(5) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R6");
        run_ev(64'(5) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R8");
        run_ev(64'(5) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R9");
        run_ev(64'(5) << 4, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, "R10");
        wr64(ent_addr(16'd6), mk_ive(16'h0, 16'h0040, 1'b0, 1'b0, 2'd1, 8'hFF));
        run_ev(64'(6) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R7");
        // disabled table
        cfg_tbl_en = 1'b0;
        run_ev(64'(6) << 4, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, "R1");
        cfg_tbl_en = 1'b1;
        // length boundary
        wr64(ent_addr(16'd299), mk_ive(16'h0, 16'h0800, 1'b0, 1'b0, 2'd3, 8'h05));
        run_ev(64'(300) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R2");
        run_ev(64'(299) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R2");
        // count clamp
        cfg_tbl_len = 17'd5000;
        wr64(ent_addr(16'd2047), mk_ive(16'h0, 16'h0010, 1'b0, 1'b0, 2'd0, 8'h02));
        run_ev(64'(2048) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
        run_ev(64'(2047) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
        cfg_src_count = 16'd10;
        run_ev(64'(10) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
        cfg_src_count = 16'd4000;
        cfg_tbl_len = 17'd300;
        // source from address OR data
        wr64(ent_addr(16'h23), mk_ive(16'h0, 16'h0300, 1'b0, 1'b0, 2'd1, 8'h20));
        run_ev(64'h200, 16'hFFE3, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
        // partition check and fast injection
        wr64(ent_addr(16'd9), mk_ive(16'h0033, 16'h0004, 1'b0, 1'b0, 2'd0, 8'h01));
        run_ev(64'(9) << 4, 16'h0, 1'b1, 16'h0034, 1'b0, 1'b0, "R5");
        run_ev(64'(9) << 4, 16'h7, 1'b1, 16'h0034, 1'b0, 1'b1, "R11");
        run_ev(64'(400) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, "R11");
        // large stride
        cfg_large = 1'b1;
        wr64(ent_addr(16'd3), mk_ive(16'h0, 16'h0444, 1'b0, 1'b0, 2'd1, 8'h30));
        run_ev(64'(3) << 4, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, "R3");
        cfg_large = 1'b0;

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            logic [15:0] s, pe;
            logic [63:0] iv;
            if (k % 50 == 0) cfg_large = $urandom % 2;
            cfg_tbl_en = ($urandom % 20) != 0;
            s = 16'($urandom % 64);
            pe = 16'($urandom % 4);
            if ($urandom % 2) begin
                iv = mk_ive(16'($urandom % 4), 16'($urandom), 1'($urandom), 1'($urandom),
                            2'($urandom), ($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 255));
                wr64(ent_addr(s | 16'($urandom % 32)), iv);
            end
            run_ev(64'(s) << 4, 16'($urandom), 1'($urandom), pe,
                   ($urandom % 7) == 0, ($urandom % 7) == 0, "");
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule